// File: doc/BRIEF.md
# Debug Breakpoint Comparator

This block watches the instruction fetch address and the load/store address of a processor pipeline and raises a hit when either one matches a programmed breakpoint. It holds up to two instruction breakpoints, each with an address. A shared enable register arms them. It also holds up to two data breakpoints, each with an address and a control word. The control word arms the breakpoint for loads, for stores or for both, and gives a mask that turns a run of low address bits into don't-care bits, so a whole aligned region can be watched.

Registers are loaded through a single-cycle write port, selected by a two-bit register code and a one-bit index. Both hit outputs and both index outputs are combinational in the current addresses. A data hit is therefore visible in the same cycle as the access request, before the access is carried out. The outputs go straight to a debug exception controller.

Top module: `dbg_break_unit`

## Requirements
- R1: After reset every address, enable and control register is zero, and both hit outputs and both index outputs are 0.
- R2: A write with `wr_sel`=0 loads the instruction enable register from the low `N_IBRK` bits of `wr_data`. Higher bits are dropped and arm nothing.
- R3: Instruction breakpoint i (address written with `wr_sel`=1, `wr_idx`=i) hits only while `fetch_valid` is high, enable bit i is set and `fetch_addr` equals its address.
- R4: Data breakpoint j has its address written with `wr_sel`=2 and its control word written with `wr_sel`=3. Control bit 31 arms it for stores (`ls_store`) and bit 30 arms it for loads (`ls_load`). With both bits clear it never hits.
- R5: The compare mask is 1 for every address bit from 31 down to 6. In bits 5:0 it follows the control bits, where a 0 makes that address bit don't-care. A data hit needs (`ls_addr` AND mask) to equal (address AND mask).
- R6: If control bits 5:0 are not a run of ones followed only by zeros, the mask keeps the leading run of ones from bit 5 downward and clears every bit below the first zero.
- R7: When several breakpoints of one kind hit together, the index output gives the lowest-numbered one.
- R8: The outputs follow the access inputs in the same cycle. A register write takes effect on the outputs in the cycle after the write edge and not in the write cycle itself.
- R9: Each index output is 0 while its hit output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 instruction enable, 1 instruction address, 2 data address, 3 data control |
| wr_idx | input | 1 | Breakpoint number for address and control writes |
| wr_data | input | 32 | Write value |
| fetch_valid | input | 1 | Fetch address is valid |
| fetch_addr | input | 32 | Instruction fetch address |
| ls_load | input | 1 | Load request |
| ls_store | input | 1 | Store request |
| ls_addr | input | 32 | Load/store address |
| ibrk_hit | output | 1 | Instruction breakpoint hit |
| ibrk_idx | output | 1 | Number of the reported instruction breakpoint |
| dbrk_hit | output | 1 | Data breakpoint hit |
| dbrk_idx | output | 1 | Number of the reported data breakpoint |

## Verification
The bench uses directed sequences to separate the cases that are easy to confuse. An enabled breakpoint is tried against a disabled one at the same address. A load is tried against a store on a breakpoint armed for one direction only. Addresses one step inside and one step outside a masked region are tried, and an address that differs only in an upper bit shows that those bits are always compared. A non-contiguous mask is probed at a bit that the raw mask would compare and the repaired mask ignores. Breakpoints that overlap test the reporting order. A write issued in the same cycle as a matching access shows when the new value takes effect. After the directed part, a run of random writes and accesses over a small address set is checked against the behavioural model on every cycle.

// File: rtl/dbg_break_unit.sv
module dbg_break_unit #(
  parameter int N_IBRK = 2,
  parameter int N_DBRK = 2,
  parameter int AW     = 32,
  parameter int MW     = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic          wr_idx,
  input  logic [AW-1:0] wr_data,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_addr,
  input  logic          ls_load,
  input  logic          ls_store,
  input  logic [AW-1:0] ls_addr,
  output logic          ibrk_hit,
  output logic          ibrk_idx,
  output logic          dbrk_hit,
  output logic          dbrk_idx
);
  localparam int SE_BIT = AW - 1;
  localparam int LE_BIT = AW - 2;

  logic [N_IBRK-1:0]         ien;
  logic [N_IBRK-1:0][AW-1:0] iaddr;
  logic [N_DBRK-1:0][AW-1:0] daddr;
  logic [N_DBRK-1:0][AW-1:0] dctl;
  logic [N_IBRK-1:0]         ih;
  logic [N_DBRK-1:0]         dh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien   <= '0;
      iaddr <= '0;
      daddr <= '0;
      dctl  <= '0;
    end else if (wr_en) begin
      if (wr_sel == 2'd0) ien <= wr_data[N_IBRK-1:0];
      for (int i = 0; i < N_IBRK; i++)
        if (wr_sel == 2'd1 && int'(wr_idx) == i) iaddr[i] <= wr_data;
      for (int j = 0; j < N_DBRK; j++) begin
        if (wr_sel == 2'd2 && int'(wr_idx) == j) daddr[j] <= wr_data;
        if (wr_sel == 2'd3 && int'(wr_idx) == j) dctl[j]  <= wr_data;
      end
    end
  end

  for (genvar i = 0; i < N_IBRK; i++) begin : g_ibrk
    assign ih[i] = fetch_valid && ien[i] && (fetch_addr == iaddr[i]);
  end

  for (genvar j = 0; j < N_DBRK; j++) begin : g_dbrk
    logic [MW:0]   run;
    logic [AW-1:0] mask;
    logic          armed;
    assign run[MW] = 1'b1;
    for (genvar k = MW - 1; k >= 0; k--) begin : g_run
      assign run[k] = run[k+1] & dctl[j][k];
    end
    assign mask  = {{(AW-MW){1'b1}}, run[MW-1:0]};
    assign armed = (ls_store && dctl[j][SE_BIT]) || (ls_load && dctl[j][LE_BIT]);
    assign dh[j] = armed && (((ls_addr ^ daddr[j]) & mask) == '0);
  end

  assign ibrk_hit = |ih;
  assign ibrk_idx = ~ih[0] & ih[N_IBRK-1];
  assign dbrk_hit = |dh;
  assign dbrk_idx = ~dh[0] & dh[N_DBRK-1];
endmodule

// File: rtl/dbg_break_unit_chk.sv
module dbg_break_unit_chk #(
  parameter int N_IBRK = 2,
  parameter int N_DBRK = 2,
  parameter int AW     = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    wr_sel,
  input logic          wr_idx,
  input logic [AW-1:0] wr_data,
  input logic          fetch_valid,
  input logic          ls_load,
  input logic          ls_store,
  input logic          ibrk_hit,
  input logic          ibrk_idx,
  input logic          dbrk_hit,
  input logic          dbrk_idx
);
  p_ihit_needs_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ibrk_hit |-> fetch_valid);

  p_dhit_needs_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dbrk_hit |-> (ls_load || ls_store));

  p_idx_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ibrk_hit |-> !ibrk_idx) and (!dbrk_hit |-> !dbrk_idx));

  p_enable_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0 && wr_data[N_IBRK-1:0] == '0) |=> !ibrk_hit);

  p_disarm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd3 && !wr_data[AW-1] && !wr_data[AW-2])
      |=> !(dbrk_hit && dbrk_idx == $past(wr_idx)));

  p_single_idx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((N_IBRK == 1) |-> !ibrk_idx) and ((N_DBRK == 1) |-> !dbrk_idx));
endmodule

bind dbg_break_unit dbg_break_unit_chk #(.N_IBRK(N_IBRK), .N_DBRK(N_DBRK), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
  .wr_data(wr_data), .fetch_valid(fetch_valid), .ls_load(ls_load), .ls_store(ls_store),
  .ibrk_hit(ibrk_hit), .ibrk_idx(ibrk_idx), .dbrk_hit(dbrk_hit), .dbrk_idx(dbrk_idx)
);

// File: tb/dbg_break_unit_tb.sv
module dbg_break_unit_tb;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_idx = 0, fetch_valid = 0, ls_load = 0, ls_store = 0;
  logic [1:0]  wr_sel = 0;
  logic [31:0] wr_data = 0, fetch_addr = 0, ls_addr = 0;
  logic ibrk_hit, ibrk_idx, dbrk_hit, dbrk_idx;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [1:0]  m_en;
  logic [31:0] m_ia [2];
  logic [31:0] m_da [2];
  logic [31:0] m_dc [2];

  always #10 clk = ~clk;

  dbg_break_unit u_dut (.*);

  function automatic logic [31:0] eff_mask(logic [31:0] c);
    logic [31:0] raw = c | 32'hFFFF_FFC0;
    int lead = 0;
    for (int b = 31; b >= 0; b--) begin
      if (!raw[b]) break;
      lead++;
    end
    return (lead == 32) ? 32'hFFFF_FFFF : (32'hFFFF_FFFF << (32 - lead));
  endfunction

  task automatic compare(string tag);
    logic ih0, ih1, dh0, dh1, e_ih, e_ii, e_dh, e_di;
    ih0 = fetch_valid && m_en[0] && fetch_addr == m_ia[0];
    ih1 = fetch_valid && m_en[1] && fetch_addr == m_ia[1];
    dh0 = ((ls_store && m_dc[0][31]) || (ls_load && m_dc[0][30])) &&
          ((ls_addr & eff_mask(m_dc[0])) == (m_da[0] & eff_mask(m_dc[0])));
    dh1 = ((ls_store && m_dc[1][31]) || (ls_load && m_dc[1][30])) &&
          ((ls_addr & eff_mask(m_dc[1])) == (m_da[1] & eff_mask(m_dc[1])));
    e_ih = ih0 || ih1;  e_ii = !ih0 && ih1;
    e_dh = dh0 || dh1;  e_di = !dh0 && dh1;
    checks++;
    if ({ibrk_hit, ibrk_idx, dbrk_hit, dbrk_idx} !== {e_ih, e_ii, e_dh, e_di}) begin
      errors++;
      $display("FAIL %s: got ih=%b ii=%b dh=%b di=%b expected ih=%b ii=%b dh=%b di=%b",
               tag, ibrk_hit, ibrk_idx, dbrk_hit, dbrk_idx, e_ih, e_ii, e_dh, e_di);
    end
  endtask

  task automatic model_write();
    if (!rst_n) begin
      m_en = 0; m_ia = '{0, 0}; m_da = '{0, 0}; m_dc = '{0, 0};
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: m_en = wr_data[1:0];
        2'd1: m_ia[wr_idx] = wr_data;
        2'd2: m_da[wr_idx] = wr_data;
        default: m_dc[wr_idx] = wr_data;
      endcase
    end
  endtask

  task automatic cyc(string tag, logic we, logic [1:0] sel, logic idx, logic [31:0] d,
                     logic fv, logic [31:0] fa, logic ld, logic st, logic [31:0] la);
    @(negedge clk);
    wr_en = we; wr_sel = sel; wr_idx = idx; wr_data = d;
    fetch_valid = fv; fetch_addr = fa; ls_load = ld; ls_store = st; ls_addr = la;
    #2 compare(tag);
    @(posedge clk);
    model_write();
  endtask

  task automatic wr(logic [1:0] sel, logic idx, logic [31:0] d);
    cyc("write", 1, sel, idx, d, 0, 0, 0, 0, 0);
  endtask

  task automatic acc(string tag, logic fv, logic [31:0] fa, logic ld, logic st, logic [31:0] la);
    cyc(tag, 0, 0, 0, 0, fv, fa, ld, st, la);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got no completion expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_en = 0; m_ia = '{0, 0}; m_da = '{0, 0}; m_dc = '{0, 0};
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state: zero address with both access kinds must not hit
    acc("R1 reset", 1, 32'h0, 1, 1, 32'h0);
    wr(1, 0, 32'h0000_1000);
    wr(1, 1, 32'h0000_2000);
    acc("R3 disabled", 1, 32'h1000, 0, 0, 0);
    // R2 only bits 1:0 of the enable are kept
    wr(0, 0, 32'hFFFF_FFFC);
    acc("R2 high bits dropped bp0", 1, 32'h1000, 0, 0, 0);
    acc("R2 high bits dropped bp1", 1, 32'h2000, 0, 0, 0);
    wr(0, 0, 32'h2);
    acc("R3 bp1 hit", 1, 32'h2000, 0, 0, 0);
    acc("R3 bp0 off", 1, 32'h1000, 0, 0, 0);
    acc("R3 no valid", 0, 32'h2000, 0, 0, 0);
    acc("R3 off by one", 1, 32'h2004, 0, 0, 0);
    wr(0, 0, 32'h3);
    wr(1, 1, 32'h0000_1000);
    acc("R7 instr both hit", 1, 32'h1000, 0, 0, 0);
    // R8 write in same cycle as matching fetch
    cyc("R8 write cycle old value", 1, 2'd1, 0, 32'h0000_3000, 1, 32'h3000, 0, 0, 0);
    acc("R8 after write", 1, 32'h3000, 0, 0, 0);
    wr(2, 0, 32'h8000_0040);
    wr(3, 0, 32'h8000_003F);
    acc("R4 store armed", 0, 0, 0, 1, 32'h8000_0040);
    acc("R4 load not armed", 0, 0, 1, 0, 32'h8000_0040);
    acc("R5 exact miss", 0, 0, 0, 1, 32'h8000_0041);
    wr(3, 0, 32'h4000_0038);
    acc("R5 region top", 0, 0, 1, 0, 32'h8000_0047);
    acc("R5 region out", 0, 0, 1, 0, 32'h8000_0048);
    acc("R5 upper bit", 0, 0, 1, 0, 32'h0000_0047);
    acc("R4 store not armed", 0, 0, 0, 1, 32'h8000_0040);
    wr(3, 0, 32'hC000_002C);
    acc("R6 repaired hit", 0, 0, 1, 0, 32'h8000_005F);
    acc("R6 repaired miss", 0, 0, 0, 1, 32'h8000_0060);
    wr(2, 1, 32'h8000_0050);
    wr(3, 1, 32'hC000_003F);
    acc("R7 data both hit", 0, 0, 1, 1, 32'h8000_0050);
    wr(3, 0, 32'h0000_003F);
    acc("R4 inactive, bp1 reported", 0, 0, 1, 1, 32'h8000_0050);
    acc("R9 idle", 0, 0, 0, 0, 32'h8000_0050);
    for (int n = 0; n < 600; n++) begin
      logic [31:0] pick [4] = '{32'h8000_0040, 32'h8000_0050, 32'h1000, 32'h3000};
      logic [31:0] d = pick[$urandom_range(3)] ^ ($urandom_range(1) ? 32'h0 : $urandom_range(63));
      if ($urandom_range(3) == 0)
        d = {$urandom_range(1) == 1, $urandom_range(1) == 1, 24'h0, 6'($urandom_range(63))};
      cyc("R3 R4 R5 R6 R7 random", $urandom_range(3) == 0, 2'($urandom_range(3)),
          1'($urandom_range(1)), d, 1'($urandom_range(1)),
          pick[$urandom_range(3)] ^ 32'($urandom_range(3) == 0),
          1'($urandom_range(1)), 1'($urandom_range(1)),
          pick[$urandom_range(3)] ^ 32'($urandom_range(127)));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule